// File: doc/BRIEF.md
# Cast-Out Victim Cache Controller

This block is a shared last-level cache that receives its contents only from lines evicted by the upper-level caches above it. Each cast-out carries a line address, a full line of data and a modified flag. The block stores every such eviction, whether modified or not. If the address is already present it does not allocate a second copy. It also answers fill requests raised by upper-level misses. A fill that hits returns the requested half-line from the resident copy. A fill that misses goes to backing memory, and the returned half passes straight through to the requester without being stored.

A line here is twice the width of an upper-level block, and a fill returns one half of it. The arrays are set-associative register arrays, and associativity and set count are parameters. When a set is full, the least-recently-used way is replaced. A modified victim leaves through a write request on the backing-memory port. An unmodified victim is dropped silently. While a write-back is outstanding, the controller holds its request inputs off through their ready signals.

Top module: `castout_llc`

## Requirements
- R1: After reset no line is valid, co_ready and fill_req_ready are high, and fill_rsp_valid and mem_req_valid are low.
- R2: A cast-out that misses is allocated whether co_dirty is 0 or 1, so a later fill to either half of that line hits without any backing-memory request.
- R3: A cast-out that hits is not allocated again. With co_dirty=1 it replaces the resident data and marks it modified. With co_dirty=0 it leaves the resident data unchanged.
- R4: A fill that hits raises fill_rsp_valid for one cycle, in the cycle after acceptance, and issues no memory request. Bit 0 of fill_req_addr selects the half: 0 returns data bits [HALF_W-1:0], 1 returns the upper half.
- R5: A fill that misses issues one read (mem_req_write=0) whose line address is fill_req_addr without bit 0. The selected half of mem_rsp_data is returned one cycle after mem_rsp_valid. The line is not allocated, so a repeat of the same fill misses again.
- R6: The set index is the low SET_W bits of the line address. On allocation the lowest-numbered invalid way is used first; otherwise the least-recently-used way is replaced. Fill hits and cast-out hits both count as uses.
- R7: A modified victim produces exactly one write request (mem_req_write=1) carrying the victim's line address and its full line data.
- R8: An unmodified victim is discarded with no backing-memory request.
- R9: While a write-back is outstanding, co_ready and fill_req_ready stay low until the write is accepted.
- R10: A memory request that is not accepted keeps mem_req_valid, mem_req_write and mem_req_addr unchanged in the next cycle.
- R11: A fill request takes priority over a cast-out. co_ready is low whenever fill_req_valid is high, so at most one request is accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| co_valid | input | 1 | Cast-out request present |
| co_ready | output | 1 | Cast-out can be accepted |
| co_addr | input | ADDR_W-1 | Line address of the evicted block |
| co_data | input | 2*HALF_W | Full line data |
| co_dirty | input | 1 | Evicted block was modified |
| fill_req_valid | input | 1 | Fill request present |
| fill_req_ready | output | 1 | Fill can be accepted |
| fill_req_addr | input | ADDR_W | Half-line address; bit 0 picks the half |
| fill_rsp_valid | output | 1 | Fill data valid for one cycle |
| fill_rsp_data | output | HALF_W | Requested half-line |
| mem_req_valid | output | 1 | Backing-memory request present |
| mem_req_ready | input | 1 | Backing memory accepts the request |
| mem_req_write | output | 1 | 1 write-back, 0 read |
| mem_req_addr | output | ADDR_W-1 | Line address of the request |
| mem_req_wdata | output | 2*HALF_W | Write-back line data |
| mem_rsp_valid | input | 1 | Read data returning |
| mem_rsp_data | input | 2*HALF_W | Returned line |

## Verification
A fill hit is answered in the cycle after its acceptance edge. A fill miss shows its read request in the cycle after acceptance. Its answer comes one cycle after the edge that samples mem_rsp_valid. A modified eviction drives its write request, and drops both ready signals, in the cycle after the cast-out is accepted. The bench drives inputs on falling edges and records expected responses, reads and write-backs in queues when it sees the accepting rising edge. Monitors pop those queues on the following falling edges, and the driver checks the one-cycle hit latency and the ready drop at exactly that falling edge.

// File: rtl/castout_llc_pkg.sv
package castout_llc_pkg;
  typedef enum logic [1:0] {
    CL_IDLE,
    CL_WBACK,
    CL_RDREQ,
    CL_RDWAIT
  } cl_state_e;
endpackage

// File: rtl/castout_llc_lookup.sv
// Tag compare and victim choice for one set.
module castout_llc_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 9,
  parameter int AGE_W = 2
) (
  input  logic [WAYS-1:0]            row_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [WAYS-1:0][AGE_W-1:0] row_age,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       hit,
  output logic [AGE_W-1:0]           hit_way,
  output logic [AGE_W-1:0]           vic_way
);
  // lowest invalid way, otherwise the way carrying the oldest age
  function automatic logic [AGE_W-1:0] pick_victim(
    input logic [WAYS-1:0]            vals,
    input logic [WAYS-1:0][AGE_W-1:0] ages
  );
    logic             found;
    logic [AGE_W-1:0] way;
    found = 1'b0;
    way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vals[w] && !found) begin
        found = 1'b1;
        way   = AGE_W'(w);
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ages[w] == AGE_W'(WAYS - 1)) way = AGE_W'(w);
      end
    end
    return way;
  endfunction

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (row_valid[w] && (row_tag[w] == req_tag)) begin
        hit     = 1'b1;
        hit_way = AGE_W'(w);
      end
    end
  end

  assign vic_way = pick_victim(row_valid, row_age);
endmodule

// File: rtl/castout_llc_age.sv
// Recency order update: used way becomes youngest, younger ways age by one.
module castout_llc_age #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2
) (
  input  logic [WAYS-1:0][AGE_W-1:0] row_age,
  input  logic [AGE_W-1:0]           use_way,
  output logic [WAYS-1:0][AGE_W-1:0] new_age
);
  function automatic logic [WAYS-1:0][AGE_W-1:0] promote(
    input logic [WAYS-1:0][AGE_W-1:0] ages,
    input logic [AGE_W-1:0]           way
  );
    logic [WAYS-1:0][AGE_W-1:0] res;
    logic [AGE_W-1:0]           ref_age;
    ref_age = ages[way];
    for (int w = 0; w < WAYS; w++) begin
      if (AGE_W'(w) == way)        res[w] = '0;
      else if (ages[w] < ref_age)  res[w] = ages[w] + AGE_W'(1);
      else                         res[w] = ages[w];
    end
    return res;
  endfunction

  assign new_age = promote(row_age, use_way);
endmodule

// File: rtl/castout_llc.sv
module castout_llc
  import castout_llc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HALF_W = 64,
  parameter int WAYS   = 4,
  parameter int SETS   = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  co_valid,
  output logic                  co_ready,
  input  logic [ADDR_W-2:0]     co_addr,
  input  logic [2*HALF_W-1:0]   co_data,
  input  logic                  co_dirty,
  input  logic                  fill_req_valid,
  output logic                  fill_req_ready,
  input  logic [ADDR_W-1:0]     fill_req_addr,
  output logic                  fill_rsp_valid,
  output logic [HALF_W-1:0]     fill_rsp_data,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_req_write,
  output logic [ADDR_W-2:0]     mem_req_addr,
  output logic [2*HALF_W-1:0]   mem_req_wdata,
  input  logic                  mem_rsp_valid,
  input  logic [2*HALF_W-1:0]   mem_rsp_data
);
  localparam int LINE_AW = ADDR_W - 1;
  localparam int LINE_W  = 2 * HALF_W;
  localparam int SET_W   = $clog2(SETS);
  localparam int TAG_W   = LINE_AW - SET_W;
  localparam int AGE_W   = (WAYS > 1) ? $clog2(WAYS) : 1;

  function automatic logic [HALF_W-1:0] pick_half(input logic [LINE_W-1:0] line,
                                                  input logic upper);
    return upper ? line[LINE_W-1:HALF_W] : line[HALF_W-1:0];
  endfunction

  // storage
  logic [WAYS-1:0]            v_q    [SETS];
  logic [WAYS-1:0]            d_q    [SETS];
  logic [WAYS-1:0][AGE_W-1:0] age_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q  [SETS];
  logic [LINE_W-1:0]          data_q [SETS][WAYS];

  cl_state_e         state_q;
  logic [LINE_AW-1:0] wb_line_q, rd_line_q;
  logic [LINE_W-1:0]  wb_data_q;
  logic               rd_half_q;
  logic               rsp_valid_q;
  logic [HALF_W-1:0]  rsp_data_q;

  // request arbitration: fill first
  logic idle;
  assign idle           = (state_q == CL_IDLE);
  assign fill_req_ready = idle;
  assign co_ready       = idle && !fill_req_valid;

  logic fill_acc, co_acc;
  assign fill_acc = fill_req_valid && fill_req_ready;
  assign co_acc   = co_valid && co_ready;

  logic [LINE_AW-1:0] lk_line;
  logic [SET_W-1:0]   lk_set;
  logic [TAG_W-1:0]   lk_tag;
  assign lk_line = fill_req_valid ? fill_req_addr[ADDR_W-1:1] : co_addr;
  assign lk_set  = lk_line[SET_W-1:0];
  assign lk_tag  = lk_line[LINE_AW-1:SET_W];

  logic                       hit;
  logic [AGE_W-1:0]           hit_way, vic_way, use_way;
  logic [WAYS-1:0][AGE_W-1:0] age_next;

  castout_llc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_lookup (
    .row_valid (v_q[lk_set]),
    .row_tag   (tag_q[lk_set]),
    .row_age   (age_q[lk_set]),
    .req_tag   (lk_tag),
    .hit       (hit),
    .hit_way   (hit_way),
    .vic_way   (vic_way)
  );

  assign use_way = hit ? hit_way : vic_way;

  castout_llc_age #(.WAYS(WAYS), .AGE_W(AGE_W)) u_age (
    .row_age (age_q[lk_set]),
    .use_way (use_way),
    .new_age (age_next)
  );

  // named events
  logic ev_fill_hit, ev_fill_miss, ev_co_hit, ev_co_alloc, ev_wb_start;
  logic vic_valid, vic_dirty;
  assign vic_valid    = v_q[lk_set][vic_way];
  assign vic_dirty    = d_q[lk_set][vic_way];
  assign ev_fill_hit  = fill_acc && hit;
  assign ev_fill_miss = fill_acc && !hit;
  assign ev_co_hit    = co_acc && hit;
  assign ev_co_alloc  = co_acc && !hit;
  assign ev_wb_start  = ev_co_alloc && vic_valid && vic_dirty;

  // state bits with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s] <= '0;
        d_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
      end
    end else begin
      if (ev_fill_hit || co_acc) age_q[lk_set] <= age_next;
      if (ev_co_hit && co_dirty) d_q[lk_set][hit_way] <= 1'b1;
      if (ev_co_alloc) begin
        v_q[lk_set][vic_way] <= 1'b1;
        d_q[lk_set][vic_way] <= co_dirty;
      end
    end
  end

  // payload arrays without reset
  always_ff @(posedge clk) begin
    if (ev_co_alloc) begin
      tag_q[lk_set][vic_way]  <= lk_tag;
      data_q[lk_set][vic_way] <= co_data;
    end else if (ev_co_hit && co_dirty) begin
      data_q[lk_set][hit_way] <= co_data;
    end
  end

  // control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CL_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      wb_line_q   <= '0;
      wb_data_q   <= '0;
      rd_line_q   <= '0;
      rd_half_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        CL_IDLE: begin
          if (ev_fill_hit) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= pick_half(data_q[lk_set][hit_way], fill_req_addr[0]);
          end else if (ev_fill_miss) begin
            rd_line_q <= lk_line;
            rd_half_q <= fill_req_addr[0];
            state_q   <= CL_RDREQ;
          end else if (ev_wb_start) begin
            wb_line_q <= {tag_q[lk_set][vic_way], lk_set};
            wb_data_q <= data_q[lk_set][vic_way];
            state_q   <= CL_WBACK;
          end
        end
        CL_WBACK:  if (mem_req_ready) state_q <= CL_IDLE;
        CL_RDREQ:  if (mem_req_ready) state_q <= CL_RDWAIT;
        CL_RDWAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= pick_half(mem_rsp_data, rd_half_q);
            state_q     <= CL_IDLE;
          end
        end
        default: state_q <= CL_IDLE;
      endcase
    end
  end

  assign fill_rsp_valid = rsp_valid_q;
  assign fill_rsp_data  = rsp_data_q;
  assign mem_req_valid  = (state_q == CL_WBACK) || (state_q == CL_RDREQ);
  assign mem_req_write  = (state_q == CL_WBACK);
  assign mem_req_addr   = (state_q == CL_WBACK) ? wb_line_q : rd_line_q;
  assign mem_req_wdata  = wb_data_q;
endmodule

// File: rtl/castout_llc_chk.sv
module castout_llc_chk #(
  parameter int LINE_AW = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               co_valid,
  input logic               co_ready,
  input logic               fill_req_valid,
  input logic               fill_req_ready,
  input logic               fill_rsp_valid,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic               mem_req_write,
  input logic [LINE_AW-1:0] mem_req_addr,
  input logic               ev_fill_hit,
  input logic               ev_fill_miss,
  input logic               ev_wb_start
);
  // R9
  wb_blocks_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (!co_ready && !fill_req_ready));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R4
  hit_answers_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_hit |=> (fill_rsp_valid && !mem_req_valid));

  // R5
  miss_reads_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_miss |=> (mem_req_valid && !mem_req_write));

  // R7
  dirty_victim_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_start |=> (mem_req_valid && mem_req_write));

  // R11
  one_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({co_valid && co_ready, fill_req_valid && fill_req_ready}));

  // R11
  fill_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> !co_ready);
endmodule

bind castout_llc castout_llc_chk #(.LINE_AW(ADDR_W - 1)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .co_valid       (co_valid),
  .co_ready       (co_ready),
  .fill_req_valid (fill_req_valid),
  .fill_req_ready (fill_req_ready),
  .fill_rsp_valid (fill_rsp_valid),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_write  (mem_req_write),
  .mem_req_addr   (mem_req_addr),
  .ev_fill_hit    (ev_fill_hit),
  .ev_fill_miss   (ev_fill_miss),
  .ev_wb_start    (ev_wb_start)
);

// File: tb/castout_llc_tb_top.sv
`timescale 1ns/1ps
module castout_llc_tb_top;
  localparam int ADDR_W  = 16;
  localparam int HALF_W  = 64;
  localparam int WAYS    = 4;
  localparam int SETS    = 64;
  localparam int LINE_AW = ADDR_W - 1;
  localparam int LINE_W  = 2 * HALF_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               co_valid = 1'b0, co_ready, co_dirty = 1'b0;
  logic [LINE_AW-1:0] co_addr = '0;
  logic [LINE_W-1:0]  co_data = '0;
  logic               fill_req_valid = 1'b0, fill_req_ready;
  logic [ADDR_W-1:0]  fill_req_addr = '0;
  logic               fill_rsp_valid;
  logic [HALF_W-1:0]  fill_rsp_data;
  logic               mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [LINE_AW-1:0] mem_req_addr;
  logic [LINE_W-1:0]  mem_req_wdata;
  logic               mem_rsp_valid = 1'b0;
  logic [LINE_W-1:0]  mem_rsp_data = '0;

  castout_llc #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .WAYS(WAYS), .SETS(SETS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .co_valid(co_valid), .co_ready(co_ready), .co_addr(co_addr),
    .co_data(co_data), .co_dirty(co_dirty),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(bit ok, string req, string what, logic [LINE_W-1:0] act,
                       logic [LINE_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // helpers
  function automatic logic [LINE_AW-1:0] mk_line(int tag, int set);
    return LINE_AW'(tag * SETS + set);
  endfunction
  function automatic logic [LINE_W-1:0] mem_line(logic [LINE_AW-1:0] a);
    int ai;
    ai = int'(a);
    return {32'hB000_0000 + ai, 32'h0000_0001 + ai * 3, 32'hD000_0000 + ai, 32'h0000_0007 + ai * 5};
  endfunction
  function automatic logic [LINE_W-1:0] mk_data(int s);
    return {32'(s * 7 + 1), 32'(s), ~32'(s), 32'(s * 13 + 5)};
  endfunction
  function automatic logic [HALF_W-1:0] half_of(logic [LINE_W-1:0] l, bit h);
    return h ? l[LINE_W-1:HALF_W] : l[HALF_W-1:0];
  endfunction

  // scoreboard queues
  logic [HALF_W-1:0]  q_fr[$];
  string              q_fr_req[$];
  logic [LINE_AW-1:0] q_rd[$];
  logic [LINE_AW-1:0] q_wb_a[$];
  logic [LINE_W-1:0]  q_wb_d[$];
  string              q_wb_req[$];
  string              lbl = "";

  // reference cache: recency tracked by timestamps
  bit                m_v    [SETS][WAYS];
  bit                m_d    [SETS][WAYS];
  int                m_tag  [SETS][WAYS];
  logic [LINE_W-1:0] m_data [SETS][WAYS];
  int                m_stamp[SETS][WAYS];
  int                m_clock = 0;

  function automatic int m_find(int set, int tag);
    int r;
    r = -1;
    for (int w = 0; w < WAYS; w++) if (m_v[set][w] && m_tag[set][w] == tag) r = w;
    return r;
  endfunction

  function automatic int m_victim(int set);
    int r;
    r = -1;
    for (int w = WAYS - 1; w >= 0; w--) if (!m_v[set][w]) r = w;
    if (r < 0) begin
      r = 0;
      for (int w = 1; w < WAYS; w++) if (m_stamp[set][w] < m_stamp[set][r]) r = w;
    end
    return r;
  endfunction

  task automatic model_castout(int tag, int set, bit dirty, logic [LINE_W-1:0] data,
                               output bit wb, output bit drop);
    int w;
    wb = 0;
    drop = 0;
    w = m_find(set, tag);
    if (w >= 0) begin
      if (dirty) begin
        m_data[set][w] = data;
        m_d[set][w] = 1;
      end
    end else begin
      w = m_victim(set);
      if (m_v[set][w] && m_d[set][w]) begin
        wb = 1;
        q_wb_a.push_back(mk_line(m_tag[set][w], set));
        q_wb_d.push_back(m_data[set][w]);
        q_wb_req.push_back(lbl != "" ? lbl : "R7");
      end else if (m_v[set][w]) begin
        drop = 1;
      end
      m_v[set][w] = 1;
      m_d[set][w] = dirty;
      m_tag[set][w] = tag;
      m_data[set][w] = data;
    end
    m_clock++;
    m_stamp[set][w] = m_clock;
  endtask

  task automatic model_fill(int tag, int set, bit h, output bit hit);
    int w;
    w = m_find(set, tag);
    hit = (w >= 0);
    if (hit) begin
      q_fr.push_back(half_of(m_data[set][w], h));
      q_fr_req.push_back(lbl != "" ? lbl : "R4");
      m_clock++;
      m_stamp[set][w] = m_clock;
    end else begin
      q_rd.push_back(mk_line(tag, set));
      q_fr.push_back(half_of(mem_line(mk_line(tag, set)), h));
      q_fr_req.push_back(lbl != "" ? lbl : "R5");
    end
  endtask

  // drivers (called at a falling edge)
  task automatic do_castout(int tag, int set, bit dirty, logic [LINE_W-1:0] data);
    bit wb, drop;
    co_valid = 1;
    co_addr  = mk_line(tag, set);
    co_dirty = dirty;
    co_data  = data;
    forever begin
      #1;
      if (co_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    model_castout(tag, set, dirty, data, wb, drop);
    @(negedge clk);
    co_valid = 0;
    if (wb) check(!co_ready && !fill_req_ready, "R9", "readies during write-back",
                  LINE_W'({co_ready, fill_req_ready}), '0);
    if (drop) check(!mem_req_valid && co_ready, "R8", "clean victim traffic",
                    LINE_W'({mem_req_valid, co_ready}), LINE_W'(1));
  endtask

  task automatic do_fill(int tag, int set, bit h);
    bit hit;
    fill_req_valid = 1;
    fill_req_addr  = {mk_line(tag, set), h};
    forever begin
      #1;
      if (fill_req_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    model_fill(tag, set, h, hit);
    @(negedge clk);
    fill_req_valid = 0;
    if (hit) check(fill_rsp_valid && !mem_req_valid, "R4", "hit latency/no read",
                   LINE_W'({fill_rsp_valid, mem_req_valid}), LINE_W'(2));
  endtask

  // monitor: fill responses
  always @(negedge clk) begin
    if (rst_n && fill_rsp_valid) begin
      if (q_fr.size() == 0) begin
        check(0, "R4", "unexpected fill response", LINE_W'(fill_rsp_data), '0);
      end else begin
        logic [HALF_W-1:0] e;
        string r;
        e = q_fr.pop_front();
        r = q_fr_req.pop_front();
        check(fill_rsp_data == e, r, "fill data", LINE_W'(fill_rsp_data), LINE_W'(e));
      end
    end
  end

  // backing memory model and request monitor
  int                 cyc = 0;
  int                 rsp_timer = 0;
  logic [LINE_AW-1:0] rsp_addr = '0;
  bit                 held = 0;
  logic [LINE_AW-1:0] held_addr = '0;
  logic               held_wr = 0;

  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 0;
    if (rsp_timer > 0) begin
      rsp_timer--;
      if (rsp_timer == 0) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = mem_line(rsp_addr);
      end
    end
    if (rst_n && held)
      check(mem_req_valid && mem_req_addr == held_addr && mem_req_write == held_wr,
            "R10", "request held", LINE_W'({mem_req_valid, mem_req_write, mem_req_addr}),
            LINE_W'({1'b1, held_wr, held_addr}));
    mem_req_ready = (cyc % 3) != 0;
    held = 0;
    if (rst_n && mem_req_valid) begin
      if (!mem_req_ready) begin
        held = 1;
        held_addr = mem_req_addr;
        held_wr = mem_req_write;
      end else if (mem_req_write) begin
        if (q_wb_a.size() == 0) begin
          check(0, "R8", "unexpected write-back", LINE_W'(mem_req_addr), '0);
        end else begin
          logic [LINE_AW-1:0] ea;
          logic [LINE_W-1:0]  ed;
          string r;
          ea = q_wb_a.pop_front();
          ed = q_wb_d.pop_front();
          r  = q_wb_req.pop_front();
          check(mem_req_addr == ea, r, "write-back address", LINE_W'(mem_req_addr), LINE_W'(ea));
          check(mem_req_wdata == ed, r, "write-back data", mem_req_wdata, ed);
        end
      end else begin
        if (q_rd.size() == 0) begin
          check(0, "R4", "unexpected read", LINE_W'(mem_req_addr), '0);
        end else begin
          logic [LINE_AW-1:0] ea;
          ea = q_rd.pop_front();
          check(mem_req_addr == ea, "R5", "read address", LINE_W'(mem_req_addr), LINE_W'(ea));
        end
        rsp_addr  = mem_req_addr;
        rsp_timer = 3;
      end
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL all watchdog act=%0d exp<150000", wd);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_v[s][w] = 0; m_d[s][w] = 0; m_tag[s][w] = 0; m_stamp[s][w] = 0;
        m_data[s][w] = '0;
      end
    repeat (5) @(negedge clk);
    rst_n = 1;
    #1;
    // R1
    check(co_ready && fill_req_ready && !fill_rsp_valid && !mem_req_valid, "R1", "reset outputs",
          LINE_W'({co_ready, fill_req_ready, fill_rsp_valid, mem_req_valid}), LINE_W'(4'b1100));
    @(negedge clk);
    lbl = "R1"; do_fill(30, 12, 0); lbl = "";

    // R2: clean cast-out allocated, both halves hit
    do_castout(1, 3, 0, mk_data(11));
    lbl = "R2"; do_fill(1, 3, 0); do_fill(1, 3, 1); lbl = "";

    // R5: miss not allocated, repeated fill misses again
    do_fill(7, 3, 1);
    do_fill(7, 3, 1);

    // R3: clean hit leaves data, dirty hit replaces it
    do_castout(2, 3, 1, mk_data(21));
    do_castout(2, 3, 0, mk_data(22));
    lbl = "R3"; do_fill(2, 3, 0); lbl = "";
    do_castout(2, 3, 1, mk_data(23));
    lbl = "R3"; do_fill(2, 3, 1); lbl = "";

    // R6 / R8: full set of clean lines, oldest dropped
    for (int t = 1; t <= 4; t++) do_castout(t, 5, 0, mk_data(50 + t));
    do_castout(5, 5, 0, mk_data(55));
    lbl = "R6"; do_fill(1, 5, 0); do_fill(2, 5, 0); lbl = "";

    // R6 / R7 / R9: fill hit refreshes way, next-oldest dirty line written back
    for (int t = 1; t <= 4; t++) do_castout(t, 7, 1, mk_data(70 + t));
    do_fill(1, 7, 1);
    lbl = "R6"; do_castout(5, 7, 1, mk_data(75)); lbl = "";

    // R6 / R3: cast-out hit refreshes way
    for (int t = 1; t <= 4; t++) do_castout(t, 9, 1, mk_data(90 + t));
    do_castout(1, 9, 0, mk_data(99));
    lbl = "R6"; do_castout(6, 9, 1, mk_data(96)); lbl = "";
    do_fill(1, 9, 0);

    // R11: fill and cast-out offered together, fill goes first
    fill_req_valid = 1; fill_req_addr = {mk_line(1, 9), 1'b1};
    co_valid = 1; co_addr = mk_line(8, 9); co_dirty = 1; co_data = mk_data(98);
    #1;
    check(!co_ready && fill_req_ready, "R11", "fill priority",
          LINE_W'({co_ready, fill_req_ready}), LINE_W'(1));
    @(posedge clk);
    begin
      bit h;
      model_fill(1, 9, 1, h);
    end
    @(negedge clk);
    fill_req_valid = 0;
    do_castout(8, 9, 1, mk_data(98));

    // mixed traffic on two sets
    begin
      int r;
      r = 32'h1ACE_0001;
      for (int i = 0; i < 400; i++) begin
        r = r * 1103515245 + 12345;
        case ((r >> 4) & 3)
          0: do_fill(1 + ((r >> 8) % 6 + 6) % 6, (r >> 16) & 1, (r >> 12) & 1);
          1: do_castout(1 + ((r >> 8) % 6 + 6) % 6, (r >> 16) & 1, 0, mk_data(r));
          default: do_castout(1 + ((r >> 8) % 6 + 6) % 6, (r >> 16) & 1, 1, mk_data(r));
        endcase
      end
    end

    repeat (30) @(negedge clk);
    check(q_fr.size() == 0 && q_rd.size() == 0, "R5", "outstanding fills",
          LINE_W'(q_fr.size() + q_rd.size()), '0);
    check(q_wb_a.size() == 0, "R7", "missing write-backs", LINE_W'(q_wb_a.size()), '0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule